// File: doc/BRIEF.md
# Resource Descriptor Stream Parser

This block walks a byte stream of plug-and-play resource descriptors and splits it into descriptors. The stream arrives one byte per cycle in which `in_valid` is high. Each descriptor begins with a tag byte. A compact tag holds the item number and a short length in that one byte. An extended tag holds a wider item number and is followed by a two-byte length. For every descriptor the parser reports its format, its item number and its payload length. It then presents each payload byte together with that byte's position inside the descriptor. The parser does not interpret the payload fields.

The parser keeps track of dependent-function groups and reports three kinds of fault: item numbers that are not defined, a group close with no open group, and a restart that cuts a descriptor short. After the terminating tag it consumes a fixed number of trailing check bytes and pulses `done`. It then ignores the stream until `start` is pulsed. Every output is registered and appears in the cycle after the byte that caused it.

Top module: `rdesc_parser`

## Requirements
- R1: After reset every output is low, and the parser treats the first accepted byte as a tag.
- R2: A tag with bit 7 clear is compact: the item number is bits [6:3] and the payload length is bits [2:0]. `desc_valid` pulses in the cycle after the tag is accepted, with `desc_large`=0, the item on `desc_item` and the length on `desc_len`.
- R3: A tag with bit 7 set is extended: the item number is bits [6:0]. The next two accepted bytes form the length, low byte first. `desc_valid` pulses with `desc_large`=1 in the cycle after the high length byte, and not before.
- R4: Payload bytes are presented on `pay_valid`/`pay_byte` one cycle after they are accepted. `pay_index` counts 0, 1, 2 and so on within the descriptor. Exactly `desc_len` bytes are treated as payload. The byte after the last payload byte is a tag.
- R5: A descriptor of length zero has no payload. The next accepted byte is a tag.
- R6: Compact items 0xA to 0xD and extended items 0x00 and 0x07 to 0x7F are undefined. For these, `err_valid` pulses together with `desc_valid`, with `err_kind`=1. The payload is still skipped by its length. Defined items raise no error.
- R7: Compact item 0x6 opens a dependent group, and compact item 0x7 closes it. A close with no open group gives `err_valid` with `err_kind`=2 alongside its `desc_valid`. A close with an open group gives no error. `start` clears the group.
- R8: Compact item 0xF terminates the stream. Whatever its length field says, it is reported with `desc_len`=TRAIL_BYTES (default 1), and exactly that many following bytes are presented as payload. `done` pulses together with the last of them.
- R9: After `done`, accepted bytes produce no output until `start` is pulsed.
- R10: If `start` is pulsed while a length byte or a payload byte is still owed, `err_valid` with `err_kind`=3 pulses in the next cycle, and the parser expects a tag again. A `start` at a tag boundary or after `done` raises no error. A byte offered in the same cycle as `start` is dropped.
- R11: Cycles with `in_valid` low change no state and produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart pulse: return to tag parsing, clear group state |
| in_valid | input | 1 | `in_byte` is accepted this cycle |
| in_byte | input | 8 | Stream byte |
| desc_valid | output | 1 | Descriptor header complete (one-cycle pulse) |
| desc_large | output | 1 | 1 = extended tag, 0 = compact tag |
| desc_item | output | 7 | Item number (compact items are zero-extended) |
| desc_len | output | 16 | Payload length of the descriptor |
| pay_valid | output | 1 | Payload byte strobe |
| pay_byte | output | 8 | Payload byte |
| pay_index | output | 16 | Position of the payload byte in its descriptor |
| err_valid | output | 1 | Fault pulse |
| err_kind | output | 2 | 1 undefined item, 2 unmatched group close, 3 truncated by restart |
| done | output | 1 | Last trailing byte after the terminator consumed |

## Verification
The bench goes after the length boundaries. It uses zero-length compact and extended items, which a design that always assumed one payload byte would misparse from that point on. It uses an extended length above 255, which exposes swapped length byte order through a wrong final index. It tests a terminator whose length field is 0, where a design that trusted the field would never raise `done`. It probes the edges of the undefined-item ranges (0x9 compared with 0xA, 0x06 compared with 0x07, and 0x00), where an off-by-one comparison flags a legal item or misses an illegal one. It also checks a repeated group close, a restart in the middle of a length field, and stalled input, where a design that advanced without `in_valid` would emit payload early.

// File: rtl/rdesc_pkg.sv
package rdesc_pkg;

  localparam int BYTE_W = 8;
  localparam int ITEM_W = 7;
  localparam int LEN_W  = 2 * BYTE_W;

  typedef enum logic [2:0] {
    PS_TAG    = 3'd0,
    PS_LEN_LO = 3'd1,
    PS_LEN_HI = 3'd2,
    PS_PAY    = 3'd3,
    PS_DONE   = 3'd4
  } pstate_e;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_RSVD      = 2'd1,
    ERR_UNMATCHED = 2'd2,
    ERR_TRUNC     = 2'd3
  } err_e;

  localparam logic [3:0] SM_GRP_OPEN  = 4'h6;
  localparam logic [3:0] SM_GRP_CLOSE = 4'h7;
  localparam logic [3:0] SM_TERM      = 4'hF;
  localparam logic [6:0] LG_LAST_DEF  = 7'h06;

  function automatic logic tag_is_ext(input logic [BYTE_W-1:0] t);
    return t[BYTE_W-1];
  endfunction

  function automatic logic [ITEM_W-1:0] tag_item(input logic [BYTE_W-1:0] t);
    if (t[BYTE_W-1]) return t[ITEM_W-1:0];
    return {3'b000, t[6:3]};
  endfunction

  function automatic logic [2:0] tag_short_len(input logic [BYTE_W-1:0] t);
    return t[2:0];
  endfunction

  function automatic logic item_undefined(input logic ext, input logic [ITEM_W-1:0] item);
    if (ext) return (item == '0) || (item > LG_LAST_DEF);
    return (item[3:0] >= 4'hA) && (item[3:0] <= 4'hD);
  endfunction

  function automatic logic [LEN_W-1:0] join_len(input logic [BYTE_W-1:0] lo,
                                                input logic [BYTE_W-1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/rdesc_tag_decode.sv
module rdesc_tag_decode
  import rdesc_pkg::*;
(
  input  logic [BYTE_W-1:0] tag,
  output logic              is_ext,
  output logic [ITEM_W-1:0] item,
  output logic [2:0]        short_len,
  output logic              undefined,
  output logic              is_term,
  output logic              is_open,
  output logic              is_close
);
  always_comb begin
    is_ext    = tag_is_ext(tag);
    item      = tag_item(tag);
    short_len = tag_short_len(tag);
    undefined = item_undefined(is_ext, item);
    is_term   = !is_ext && (item[3:0] == SM_TERM);
    is_open   = !is_ext && (item[3:0] == SM_GRP_OPEN);
    is_close  = !is_ext && (item[3:0] == SM_GRP_CLOSE);
  end
endmodule

// File: rtl/rdesc_len_ctr.sv
module rdesc_len_ctr #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic [CW-1:0] index,
  output logic          last
);
  logic [CW-1:0] rem_q;
  logic [CW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (clr) begin
      rem_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      rem_q <= load_val;
      idx_q <= '0;
    end else if (step) begin
      rem_q <= rem_q - 1'b1;
      idx_q <= idx_q + 1'b1;
    end
  end

  assign index = idx_q;
  assign last  = (rem_q == CW'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> rem_q != '0); // R4
endmodule

// File: rtl/rdesc_dep_track.sv
module rdesc_dep_track (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic open_evt,
  input  logic close_evt,
  output logic unmatched
);
  logic open_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         open_q <= 1'b0;
    else if (clr)       open_q <= 1'b0;
    else if (open_evt)  open_q <= 1'b1;
    else if (close_evt) open_q <= 1'b0;
  end

  assign unmatched = close_evt && !open_q;

  AST_CLOSE_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (close_evt && !clr) |=> !open_q); // R7
  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (open_evt && !clr) |=> open_q); // R7
endmodule

// File: rtl/rdesc_parser.sv
module rdesc_parser
  import rdesc_pkg::*;
#(
  parameter int TRAIL_BYTES = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              desc_valid,
  output logic              desc_large,
  output logic [6:0]        desc_item,
  output logic [15:0]       desc_len,
  output logic              pay_valid,
  output logic [7:0]        pay_byte,
  output logic [15:0]       pay_index,
  output logic              err_valid,
  output logic [1:0]        err_kind,
  output logic              done
);
  localparam logic [LEN_W-1:0] TRAIL_LEN = LEN_W'(TRAIL_BYTES);

  pstate_e st_q, st_n;

  logic              dec_ext, dec_undef, dec_term, dec_open, dec_close;
  logic [ITEM_W-1:0] dec_item;
  logic [2:0]        dec_slen;

  logic              accept, tag_evt, lenlo_evt, lenhi_evt, pay_evt;
  logic              owed, trunc_evt, short_hdr;
  logic              ctr_load, ctr_last, grp_unmatched;
  logic [LEN_W-1:0]  ctr_val, ctr_idx, ext_len;

  logic              term_q, ext_undef_q;
  logic [ITEM_W-1:0] ext_item_q;
  logic [BYTE_W-1:0] len_lo_q;

  rdesc_tag_decode u_dec (
    .tag(in_byte), .is_ext(dec_ext), .item(dec_item), .short_len(dec_slen),
    .undefined(dec_undef), .is_term(dec_term), .is_open(dec_open), .is_close(dec_close)
  );

  assign accept    = in_valid && !start && (st_q != PS_DONE);
  assign tag_evt   = accept && (st_q == PS_TAG);
  assign lenlo_evt = accept && (st_q == PS_LEN_LO);
  assign lenhi_evt = accept && (st_q == PS_LEN_HI);
  assign pay_evt   = accept && (st_q == PS_PAY);
  assign short_hdr = tag_evt && !dec_ext;
  assign owed      = (st_q == PS_LEN_LO) || (st_q == PS_LEN_HI) || (st_q == PS_PAY);
  assign trunc_evt = start && owed;
  assign ext_len   = join_len(len_lo_q, in_byte);

  always_comb begin
    ctr_load = 1'b0;
    ctr_val  = '0;
    if (short_hdr) begin
      ctr_load = 1'b1;
      ctr_val  = dec_term ? TRAIL_LEN : LEN_W'(dec_slen);
    end else if (lenhi_evt) begin
      ctr_load = 1'b1;
      ctr_val  = ext_len;
    end
  end

  rdesc_len_ctr #(.CW(LEN_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .clr(start), .load(ctr_load), .load_val(ctr_val),
    .step(pay_evt), .index(ctr_idx), .last(ctr_last)
  );

  rdesc_dep_track u_grp (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .open_evt(short_hdr && dec_open), .close_evt(short_hdr && dec_close),
    .unmatched(grp_unmatched)
  );

  always_comb begin
    st_n = st_q;
    if (start) st_n = PS_TAG;
    else if (accept) begin
      case (st_q)
        PS_TAG: begin
          if (dec_ext)                    st_n = PS_LEN_LO;
          else if (dec_term)              st_n = PS_PAY;
          else if (dec_slen != 3'd0)      st_n = PS_PAY;
          else                            st_n = PS_TAG;
        end
        PS_LEN_LO: st_n = PS_LEN_HI;
        PS_LEN_HI: st_n = (ext_len != '0) ? PS_PAY : PS_TAG;
        PS_PAY:    if (ctr_last) st_n = term_q ? PS_DONE : PS_TAG;
        default:   st_n = PS_TAG;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_TAG;
      term_q      <= 1'b0;
      ext_undef_q <= 1'b0;
      ext_item_q  <= '0;
      len_lo_q    <= '0;
    end else begin
      st_q <= st_n;
      if (start) term_q <= 1'b0;
      else if (short_hdr) term_q <= dec_term;
      if (tag_evt && dec_ext) begin
        ext_item_q  <= dec_item;
        ext_undef_q <= dec_undef;
      end
      if (lenlo_evt) len_lo_q <= in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_valid <= 1'b0;
      desc_large <= 1'b0;
      desc_item  <= '0;
      desc_len   <= '0;
      pay_valid  <= 1'b0;
      pay_byte   <= '0;
      pay_index  <= '0;
      err_valid  <= 1'b0;
      err_kind   <= ERR_NONE;
      done       <= 1'b0;
    end else begin
      desc_valid <= short_hdr || lenhi_evt;
      pay_valid  <= pay_evt;
      done       <= pay_evt && ctr_last && term_q;
      err_valid  <= 1'b0;
      err_kind   <= ERR_NONE;
      if (short_hdr) begin
        desc_large <= 1'b0;
        desc_item  <= dec_item;
        desc_len   <= ctr_val;
        if (dec_undef) begin
          err_valid <= 1'b1;
          err_kind  <= ERR_RSVD;
        end else if (grp_unmatched) begin
          err_valid <= 1'b1;
          err_kind  <= ERR_UNMATCHED;
        end
      end
      if (lenhi_evt) begin
        desc_large <= 1'b1;
        desc_item  <= ext_item_q;
        desc_len   <= ext_len;
        if (ext_undef_q) begin
          err_valid <= 1'b1;
          err_kind  <= ERR_RSVD;
        end
      end
      if (pay_evt) begin
        pay_byte  <= in_byte;
        pay_index <= ctr_idx;
      end
      if (trunc_evt) begin
        err_valid <= 1'b1;
        err_kind  <= ERR_TRUNC;
      end
    end
  end

  AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> pay_index < desc_len); // R4
  AST_HDR_NOT_PAY: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !pay_valid); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_DONE && !start) |=> !(desc_valid || pay_valid || err_valid)); // R9
  AST_TRUNC_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    trunc_evt |=> (err_valid && err_kind == ERR_TRUNC)); // R10
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !start) |=> !(desc_valid || pay_valid || err_valid || done)); // R11
endmodule

// File: tb/tb_rdesc_parser.sv
`timescale 1ns/1ps
module tb_rdesc_parser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic in_valid = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic desc_valid, desc_large, pay_valid, err_valid, done;
  logic [6:0] desc_item;
  logic [15:0] desc_len, pay_index;
  logic [7:0] pay_byte;
  logic [1:0] err_kind;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  rdesc_parser dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid), .in_byte(in_byte),
    .desc_valid(desc_valid), .desc_large(desc_large), .desc_item(desc_item),
    .desc_len(desc_len), .pay_valid(pay_valid), .pay_byte(pay_byte),
    .pay_index(pay_index), .err_valid(err_valid), .err_kind(err_kind), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic restart();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic exp_desc(input string req, input bit lg, input int item, input int len,
                          input int ek);
    check(desc_valid == 1'b1, req, "desc_valid", desc_valid, 1);
    check(desc_large == lg, req, "desc_large", desc_large, lg);
    check(desc_item == item[6:0], req, "desc_item", desc_item, item);
    check(desc_len == len[15:0], req, "desc_len", desc_len, len);
    check(err_valid == (ek != 0), req, "err_valid", err_valid, ek != 0);
    if (ek != 0) check(err_kind == ek[1:0], req, "err_kind", err_kind, ek);
  endtask

  task automatic exp_pay(input string req, input int b, input int idx);
    check(pay_valid == 1'b1, req, "pay_valid", pay_valid, 1);
    check(pay_byte == b[7:0], req, "pay_byte", pay_byte, b);
    check(pay_index == idx[15:0], req, "pay_index", pay_index, idx);
    check(desc_valid == 1'b0, req, "desc_valid during payload", desc_valid, 0);
  endtask

  task automatic exp_quiet(input string req);
    check(!(desc_valid || pay_valid || err_valid || done), req, "outputs quiet",
          {desc_valid, pay_valid, err_valid, done}, 0);
  endtask

  task automatic t_reset();
    exp_quiet("R1");
    check(desc_len == 0 && pay_index == 0, "R1", "reset fields", desc_len, 0);
    push(8'h08);
    exp_desc("R1", 1'b0, 1, 0, 0);
  endtask

  task automatic t_small();
    restart();
    push(8'h22);
    exp_desc("R2", 1'b0, 4, 2, 0);
    push(8'hAA); exp_pay("R4", 8'hAA, 0);
    push(8'hBB); exp_pay("R4", 8'hBB, 1);
    push(8'h08); exp_desc("R5", 1'b0, 1, 0, 0);
    push(8'h11); exp_desc("R5", 1'b0, 2, 1, 0);
    push(8'h3C); exp_pay("R4", 8'h3C, 0);
    push(8'h4F); exp_desc("R2", 1'b0, 9, 7, 0);
    for (int i = 0; i < 7; i++) begin
      push(8'(i + 8'h40));
      exp_pay("R4", i + 8'h40, i);
    end
    push(8'h08); exp_desc("R4", 1'b0, 1, 0, 0);
  endtask

  task automatic t_large();
    restart();
    push(8'h81);
    exp_quiet("R3");
    push(8'h03);
    exp_quiet("R3");
    push(8'h00);
    exp_desc("R3", 1'b1, 8'h01, 3, 0);
    for (int i = 0; i < 3; i++) begin
      push(8'(8'hC0 + i));
      exp_pay("R4", 8'hC0 + i, i);
    end
    push(8'h84); push(8'h02); push(8'h01);
    exp_desc("R3", 1'b1, 8'h04, 258, 0);
    for (int i = 0; i < 258; i++) begin
      push(8'(i));
      if (i == 0 || i == 257) exp_pay("R4", i & 8'hFF, i);
    end
    push(8'h86); push(8'h00); push(8'h00);
    exp_desc("R5", 1'b1, 8'h06, 0, 0);
    push(8'h10); exp_desc("R5", 1'b0, 2, 0, 0);
  endtask

  task automatic t_undefined();
    restart();
    push(8'h50); exp_desc("R6", 1'b0, 8'hA, 0, 1);
    push(8'h48); exp_desc("R6", 1'b0, 8'h9, 0, 0);
    push(8'h69); exp_desc("R6", 1'b0, 8'hD, 1, 1);
    push(8'h77); exp_pay("R6", 8'h77, 0);
    push(8'h70); exp_desc("R6", 1'b0, 8'hE, 0, 0);
    push(8'h87); push(8'h01); push(8'h00);
    exp_desc("R6", 1'b1, 8'h07, 1, 1);
    push(8'h55); exp_pay("R6", 8'h55, 0);
    push(8'h80); push(8'h00); push(8'h00);
    exp_desc("R6", 1'b1, 8'h00, 0, 1);
    push(8'h86); push(8'h00); push(8'h00);
    exp_desc("R6", 1'b1, 8'h06, 0, 0);
    push(8'hFF); push(8'h00); push(8'h00);
    exp_desc("R6", 1'b1, 8'h7F, 0, 1);
  endtask

  task automatic t_groups();
    restart();
    push(8'h38); exp_desc("R7", 1'b0, 7, 0, 2);
    push(8'h30); exp_desc("R7", 1'b0, 6, 0, 0);
    push(8'h31); exp_desc("R7", 1'b0, 6, 1, 0);
    push(8'h01); exp_pay("R7", 8'h01, 0);
    push(8'h38); exp_desc("R7", 1'b0, 7, 0, 0);
    push(8'h38); exp_desc("R7", 1'b0, 7, 0, 2);
    push(8'h30); exp_desc("R7", 1'b0, 6, 0, 0);
    restart();
    push(8'h38); exp_desc("R7", 1'b0, 7, 0, 2);
  endtask

  task automatic t_terminate();
    restart();
    push(8'h79); exp_desc("R8", 1'b0, 8'hF, 1, 0);
    check(done == 1'b0, "R8", "done early", done, 0);
    push(8'h5A); exp_pay("R8", 8'h5A, 0);
    check(done == 1'b1, "R8", "done", done, 1);
    push(8'h22); exp_quiet("R9");
    push(8'h81); exp_quiet("R9");
    idle(1);     exp_quiet("R9");
    restart();
    check(err_valid == 1'b0, "R10", "start after done", err_valid, 0);
    push(8'h78); exp_desc("R8", 1'b0, 8'hF, 1, 0);
    push(8'hE3); exp_pay("R8", 8'hE3, 0);
    check(done == 1'b1, "R8", "done len field 0", done, 1);
    restart();
  endtask

  task automatic t_truncate();
    restart();
    check(err_valid == 1'b0, "R10", "start at tag boundary", err_valid, 0);
    push(8'h81); push(8'h05);
    restart();
    check(err_valid == 1'b1 && err_kind == 2'd3, "R10", "trunc in length",
          {err_valid, err_kind}, 3'b111);
    push(8'h08); exp_desc("R10", 1'b0, 1, 0, 0);
    push(8'h12); push(8'h99);
    restart();
    check(err_valid == 1'b1 && err_kind == 2'd3, "R10", "trunc in payload",
          {err_valid, err_kind}, 3'b111);
    start = 1'b1; in_valid = 1'b1; in_byte = 8'h11;
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0;
    exp_quiet("R10");
    push(8'h10); exp_desc("R10", 1'b0, 2, 0, 0);
  endtask

  task automatic t_stall();
    restart();
    push(8'h21); exp_desc("R11", 1'b0, 4, 1, 0);
    idle(1); exp_quiet("R11");
    idle(2); exp_quiet("R11");
    push(8'h6D); exp_pay("R11", 8'h6D, 0);
    idle(1); exp_quiet("R11");
    push(8'h08); exp_desc("R11", 1'b0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_large();
    t_undefined();
    t_groups();
    t_terminate();
    t_truncate();
    t_stall();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule